// File: doc/BRIEF.md
# Indexed Configuration RAM Port

This block gives a host two byte-wide I/O locations for reaching a small, battery-backed configuration store. One location, the selector, holds a byte. Its low seven bits choose a storage location. Its top bit masks the non-maskable interrupt and is driven out of the block as its own signal. The other location, the window, reads or writes whichever byte the selector points at. The selector keeps its value after an access, so a host can hit the same byte many times through the window without writing the selector again.

The store holds 128 bytes by default. A 64-byte build is also available; in that build the upper half of the selector range folds back onto the lower half. The first fourteen locations are not held in the local RAM. Accesses to them go out over a strobe, address and data interface to an attached clock register file. Two of those fourteen, at 0Ch and 0Dh, are status registers that can only be read. The block drops host writes to them.

Top module: `idxcfg_port`

## Requirements
- R1: While reset is asserted and after it is released, `nmiMask` is 1 and the selector reads back as 80h until the host writes it.
- R2: A host write to the selector (`hostAddr`=0) stores all eight bits. Bit 7 appears on `nmiMask` from the next cycle. A read of the selector returns the full stored byte.
- R3: With the selector pointing at a location at or above 0Eh, a window write (`hostAddr`=1) stores the byte and a later window read returns it. Repeated window accesses keep hitting the same byte until the selector is rewritten.
- R4: Selector bit 7 is never part of the address. Selector values 20h and A0h reach the same byte.
- R5: A window read of a location below 0Eh raises `rtcStb` with `rtcWr`=0 and `rtcAddr` set to that location. It returns `rtcRdata` on `hostRdata` in the same cycle.
- R6: A window write to a clock location 00h-0Bh raises `rtcStb` and `rtcWr` together, with `rtcAddr` set to the location and `rtcWdata` equal to the host byte.
- R7: A window write to the read-only clock locations 0Ch or 0Dh is ignored: `rtcStb` stays 0.
- R8: In the 64-byte build the effective address is selector bits 5..0, so locations 40h-7Fh alias 00h-3Fh, the clock region included.
- R9: Selector accesses, and window accesses to locations at or above 0Eh, never raise `rtcStb`.
- R10: `hostRdata` is 00h in every cycle without a host read, and `rtcStb` is 0 whenever `hostSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostAddr | input | 1 | 0 selects the selector, 1 selects the window |
| hostWr | input | 1 | 1 for a write, 0 for a read |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, valid in the access cycle |
| nmiMask | output | 1 | 1 masks the non-maskable interrupt |
| rtcStb | output | 1 | Clock register file access strobe |
| rtcWr | output | 1 | Clock register file write qualifier |
| rtcAddr | output | 4 | Clock register index 0-13 |
| rtcWdata | output | 8 | Clock register write byte |
| rtcRdata | input | 8 | Clock register read byte, combinational from rtcAddr |

## Verification
The assertions assume that the host raises `hostSel` for one cycle per access with stable qualifiers. They also assume that the clock register file answers `rtcRdata` in the same cycle as `rtcAddr`. The bench drives every access as a single-cycle pulse set up at the falling edge. It models the clock register file as a pure function of `rtcAddr`, so both assumptions always hold. Random selector bytes cover both values of bit 7 and the full address range. They are applied to a 128-byte and a 64-byte instance at once, which exercises the aliasing and the clock-region filter against the same stimulus.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;
  // number of locations routed to the clock register file
  localparam int CLK_LOCS = 14;
  // the two topmost clock locations are read-only status
  localparam int RO_FIRST = CLK_LOCS - 2;
  localparam int RTC_AW   = $clog2(CLK_LOCS);

  typedef struct packed {
    logic idxWe;   // load selector
    logic ramWe;   // write local RAM
    logic rtcSel;  // strobe clock register file
    logic rtcWe;   // clock register write
    logic rdIdx;   // return selector
    logic rdRtc;   // return clock read byte
    logic rdRam;   // return RAM byte
  } ctlStb_t;
endpackage

// File: rtl/idxcfg_ctl.sv
module idxcfg_ctl
  import idxcfg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              hostSel,
  input  logic              hostAddr,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] effAddr,
  output ctlStb_t           stb
);
  logic inClk;
  logic roLoc;
  logic winAcc;
  logic selAcc;

  always_comb begin
    inClk  = int'(effAddr) < CLK_LOCS;
    roLoc  = inClk && (int'(effAddr) >= RO_FIRST);
    winAcc = hostSel && hostAddr;
    selAcc = hostSel && !hostAddr;

    stb.idxWe  = selAcc && hostWr;
    stb.rdIdx  = selAcc && !hostWr;
    stb.ramWe  = winAcc && hostWr && !inClk;
    stb.rdRam  = winAcc && !hostWr && !inClk;
    stb.rdRtc  = winAcc && !hostWr && inClk;
    stb.rtcWe  = winAcc && hostWr && inClk && !roLoc;
    stb.rtcSel = stb.rdRtc || stb.rtcWe;
  end
endmodule

// File: rtl/idxcfg_dp.sv
module idxcfg_dp
  import idxcfg_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [7:0]        hostWdata,
  input  logic [7:0]        rtcRdata,
  output logic [ADDR_W-1:0] effAddr,
  output logic [7:0]        idxReg,
  output logic [7:0]        hostRdata
);
  logic [7:0] mem [DEPTH];

  // selector: reset masks the NMI, address zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idxReg <= 8'h80;
    else if (stb.idxWe) idxReg <= hostWdata;
  end

  // address width picks the alias behaviour; bit 7 never reaches it
  generate
    if (ADDR_W < 7) begin : g_fold
      assign effAddr = idxReg[ADDR_W-1:0];
    end else begin : g_full
      assign effAddr = idxReg[6:0];
    end
  endgenerate

  // battery-backed contents are not reset
  always_ff @(posedge clk) begin
    if (stb.ramWe) mem[effAddr] <= hostWdata;
  end

  always_comb begin
    if (stb.rdIdx)      hostRdata = idxReg;
    else if (stb.rdRtc) hostRdata = rtcRdata;
    else if (stb.rdRam) hostRdata = mem[effAddr];
    else                hostRdata = 8'h00;
  end
endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
  import idxcfg_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostAddr,
  input  logic              hostWr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              nmiMask,
  output logic              rtcStb,
  output logic              rtcWr,
  output logic [RTC_AW-1:0] rtcAddr,
  output logic [7:0]        rtcWdata,
  input  logic [7:0]        rtcRdata
);
  localparam int ADDR_W = $clog2(DEPTH);

  ctlStb_t           stb;
  logic [ADDR_W-1:0] effAddr;
  logic [7:0]        idxReg;

  idxcfg_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .hostSel (hostSel),
    .hostAddr(hostAddr),
    .hostWr  (hostWr),
    .effAddr (effAddr),
    .stb     (stb)
  );

  idxcfg_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostWdata(hostWdata),
    .rtcRdata (rtcRdata),
    .effAddr  (effAddr),
    .idxReg   (idxReg),
    .hostRdata(hostRdata)
  );

  assign nmiMask  = idxReg[7];
  assign rtcStb   = stb.rtcSel;
  assign rtcWr    = stb.rtcWe;
  assign rtcAddr  = effAddr[RTC_AW-1:0];
  assign rtcWdata = hostWdata;
endmodule

// File: rtl/idxcfg_chk.sv
module idxcfg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostSel,
  input logic       hostAddr,
  input logic       hostWr,
  input logic [7:0] hostWdata,
  input logic [7:0] hostRdata,
  input logic       nmiMask,
  input logic       rtcStb,
  input logic       rtcWr,
  input logic [3:0] rtcAddr,
  input logic [7:0] rtcWdata
);
  // R1: the first cycle out of reset still has the NMI masked
  a_r1_nmi_masked_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> nmiMask);

  // R2: a selector write moves bit 7 to the mask output
  a_r2_mask_follows_selector: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostAddr && hostWr) |=> nmiMask == $past(hostWdata[7]));

  // R5: clock strobes only come from window accesses inside the clock region
  a_r5_rtc_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    rtcStb |-> (hostSel && hostAddr && rtcAddr < 4'd14));

  // R6: a clock write carries the host byte
  a_r6_rtc_write_data: assert property (@(posedge clk) disable iff (!rstN)
    (rtcStb && rtcWr) |-> (hostWr && rtcWdata == hostWdata));

  // R7: read-only status locations are never written
  a_r7_no_ro_write: assert property (@(posedge clk) disable iff (!rstN)
    (rtcStb && rtcWr) |-> (rtcAddr != 4'd12 && rtcAddr != 4'd13));

  // R10: idle bus returns zero and never strobes the clock file
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hostSel |-> (hostRdata == 8'h00 && !rtcStb));
endmodule

bind idxcfg_port idxcfg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostSel  (hostSel),
  .hostAddr (hostAddr),
  .hostWr   (hostWr),
  .hostWdata(hostWdata),
  .hostRdata(hostRdata),
  .nmiMask  (nmiMask),
  .rtcStb   (rtcStb),
  .rtcWr    (rtcWr),
  .rtcAddr  (rtcAddr),
  .rtcWdata (rtcWdata)
);

// File: tb/test_idxcfg_port.sv
module test_idxcfg_port;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic       hostSel, hostAddr, hostWr;
  logic [7:0] hostWdata;
  logic [7:0] rdata [2];
  logic       nmi   [2];
  logic       stb   [2];
  logic       wr    [2];
  logic [3:0] ra    [2];
  logic [7:0] rw    [2];
  logic [7:0] rr    [2];

  function automatic logic [7:0] rtcFn(input logic [3:0] a);
    return 8'hA0 ^ {a, a};
  endfunction

  assign rr[0] = rtcFn(ra[0]);
  assign rr[1] = rtcFn(ra[1]);

  idxcfg_port #(.DEPTH(128)) i_idxcfg_port (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(rdata[0]), .nmiMask(nmi[0]), .rtcStb(stb[0]),
    .rtcWr(wr[0]), .rtcAddr(ra[0]), .rtcWdata(rw[0]), .rtcRdata(rr[0]));

  idxcfg_port #(.DEPTH(64)) i_idxcfg_port_64 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(rdata[1]), .nmiMask(nmi[1]), .rtcStb(stb[1]),
    .rtcWr(wr[1]), .rtcAddr(ra[1]), .rtcWdata(rw[1]), .rtcRdata(rr[1]));

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] expIdx;
  logic [7:0] mem [2][128];
  bit         vld [2][128];

  function automatic int effOf(input int k);
    return (k == 0) ? int'(expIdx[6:0]) : int'(expIdx[5:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input bit a, input bit w, input logic [7:0] d);
    @(negedge clk);
    hostSel = s; hostAddr = a; hostWr = w; hostWdata = d;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 8'h00);
    for (int k = 0; k < 2; k++) begin
      chk(rdata[k] == 8'h00, "R10 idle rdata", rdata[k], 8'h00);
      chk(stb[k] == 1'b0, "R10 idle rtcStb", {7'd0, stb[k]}, 8'h00);
    end
    @(posedge clk);
  endtask

  task automatic wrIdx(input logic [7:0] b);
    drive(1, 0, 1, b);
    for (int k = 0; k < 2; k++) begin
      chk(rdata[k] == 8'h00, "R10 write rdata", rdata[k], 8'h00);
      chk(stb[k] == 1'b0, "R9 selector write rtcStb", {7'd0, stb[k]}, 8'h00);
    end
    @(posedge clk);
    #1;
    expIdx = b;
    for (int k = 0; k < 2; k++)
      chk(nmi[k] == b[7], "R2 nmiMask", {7'd0, nmi[k]}, {7'd0, b[7]});
  endtask

  task automatic rdIdx();
    drive(1, 0, 0, 8'h00);
    for (int k = 0; k < 2; k++) begin
      chk(rdata[k] == expIdx, "R2 selector readback", rdata[k], expIdx);
      chk(stb[k] == 1'b0, "R9 selector read rtcStb", {7'd0, stb[k]}, 8'h00);
    end
    @(posedge clk);
  endtask

  task automatic wrData(input logic [7:0] b);
    int e;
    drive(1, 1, 1, b);
    for (int k = 0; k < 2; k++) begin
      e = effOf(k);
      if (e < 14) begin
        if (e >= 12) begin
          chk(stb[k] == 1'b0, "R7 read-only write rtcStb", {7'd0, stb[k]}, 8'h00);
        end else begin
          chk(stb[k] && wr[k], "R6 rtcStb/rtcWr", {6'd0, stb[k], wr[k]}, 8'h03);
          chk(ra[k] == 4'(e), "R6 rtcAddr", {4'd0, ra[k]}, 8'(e));
          chk(rw[k] == b, "R6 rtcWdata", rw[k], b);
        end
      end else begin
        chk(stb[k] == 1'b0, "R9 RAM write rtcStb", {7'd0, stb[k]}, 8'h00);
      end
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      e = effOf(k);
      if (e >= 14) begin
        mem[k][e] = b;
        vld[k][e] = 1'b1;
      end
    end
  endtask

  task automatic rdData(input string tag);
    int e;
    drive(1, 1, 0, 8'h00);
    for (int k = 0; k < 2; k++) begin
      e = effOf(k);
      if (e < 14) begin
        chk(stb[k] && !wr[k], "R5 rtcStb read", {6'd0, stb[k], wr[k]}, 8'h02);
        chk(ra[k] == 4'(e), "R5 rtcAddr", {4'd0, ra[k]}, 8'(e));
        chk(rdata[k] == rtcFn(4'(e)), "R5 clock read data", rdata[k], rtcFn(4'(e)));
      end else begin
        chk(stb[k] == 1'b0, "R9 RAM read rtcStb", {7'd0, stb[k]}, 8'h00);
        if (vld[k][e]) chk(rdata[k] == mem[k][e], tag, rdata[k], mem[k][e]);
      end
    end
    @(posedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 128; a++) begin
        vld[k][a] = 1'b0;
        mem[k][a] = 8'h00;
      end
    void'($urandom(32'd2024));
    rstN = 1'b0;
    hostSel = 0; hostAddr = 0; hostWr = 0; hostWdata = 8'h00;
    repeat (3) @(posedge clk);
    // R1: reset state, selector read while reset held
    drive(1, 0, 0, 8'h00);
    for (int k = 0; k < 2; k++) begin
      chk(nmi[k] == 1'b1, "R1 nmiMask in reset", {7'd0, nmi[k]}, 8'h01);
      chk(rdata[k] == 8'h80, "R1 selector reset value", rdata[k], 8'h80);
    end
    drive(0, 0, 0, 8'h00);
    rstN = 1'b1;
    expIdx = 8'h80;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++)
      chk(nmi[k] == 1'b1, "R1 nmiMask after reset", {7'd0, nmi[k]}, 8'h01);

    // R3: store and repeated reads
    wrIdx(8'h20);
    wrData(8'h5A);
    rdData("R3 RAM readback");
    rdData("R3 repeated read");
    // R4: bit 7 is not address
    wrIdx(8'hA0);
    rdData("R4 bit7 alias read");
    wrData(8'hC3);
    wrIdx(8'h20);
    rdData("R4 bit7 alias write");
    // R7 / R6 / R5 clock region
    wrIdx(8'h0C); wrData(8'hFF);
    wrIdx(8'h8D); wrData(8'h11);
    wrIdx(8'h0B); wrData(8'h26);
    wrIdx(8'h00); wrData(8'h59);
    wrIdx(8'h03); rdData("R5 clock");
    // R8: small build folds 50h onto 10h and 45h onto clock 05h
    wrIdx(8'h50); wrData(8'h3C);
    wrIdx(8'h10); rdData("R8 alias readback");
    wrIdx(8'h45); rdData("R8 alias clock");
    wrIdx(8'h7F); wrData(8'h77);
    wrIdx(8'h3F); rdData("R8 alias top");
    idle();
    rdIdx();

    for (int i = 0; i < 800; i++) begin
      case ($urandom % 6)
        0: wrIdx(8'($urandom));
        1: wrIdx(8'($urandom % 20) | (($urandom % 2 == 0) ? 8'h80 : 8'h00));
        2: wrData(8'($urandom));
        3: rdData("R3 random readback");
        4: rdIdx();
        default: idle();
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule